// File: doc/BRIEF.md
# Triggered Dual Programmable Delay Pulser

This block paces a sweep display. It divides a slow timebase, given as a one-cycle enable, into a narrow periodic frame trigger. The trigger is brought out for an external sweep circuit. Inside the block, the same trigger starts two independent 8-bit down-counters: a coarse channel and a fine channel. Each counter runs on the fast system clock. It loads its preset, counts down to zero, and fires a single one-cycle scan pulse. After that it stays idle until the next frame trigger arrives, so each channel produces exactly one pulse per frame.

A host processor places each scan pulse within the frame by writing the channel's preset through a small register bus. A write lands only when the write strobe, the I/O-space select and the channel address are all present at once. A preset changed while its channel is counting does not disturb the current count. The new value is loaded at the next trigger. Both presets can be read back combinationally at their addresses.

With the default parameters the block runs on a 2 MHz clock and takes a 32 kHz enable. Twenty enables form a frame, which gives a 1600 Hz trigger.

Top module: `sweep_delay_pulser`

## Requirements
- R1: While reset is asserted and right after it, `frame_trig`, `coarse_pulse` and `fine_pulse` are low, and reading address 0 or address 1 returns 0.
- R2: `frame_trig` is high for exactly one clock cycle. It rises in the cycle after every DIV-th `tick_en` pulse, counted from reset (DIV = 20 by default). No other cycle raises it.
- R3: If the coarse preset is P when a trigger occurs in cycle T, `coarse_pulse` is high in cycle T+1+P only. The pulse is one cycle wide.
- R4: If the fine preset is P when a trigger occurs in cycle T, `fine_pulse` is high in cycle T+1+P only. This timing is independent of the coarse channel.
- R5: The preset range ends map to fixed delays. A preset of 0 fires in the cycle right after the trigger, and a preset of 255 fires 256 cycles after it.
- R6: A clock edge with `bus_wr`=1 and `bus_io_sel`=1 stores `bus_wdata` into the coarse preset when `bus_addr`=0, or into the fine preset when `bus_addr`=1. `bus_rdata` returns the coarse preset at address 0 and the fine preset at address 1, combinationally.
- R7: A write with `bus_io_sel`=0, with `bus_wr`=0, or to any address other than 0 or 1 changes neither preset. Other addresses read 0.
- R8: A preset write made while its channel is counting leaves that frame's pulse at the old position. The new value is used from the next trigger on.
- R9: After a channel fires, it fires no more pulses until another trigger occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (2 MHz nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle timebase enable (32 kHz nominal) |
| bus_addr | input | ADDR_W | Host register address |
| bus_wdata | input | CNT_W | Host write data |
| bus_wr | input | 1 | Host write strobe |
| bus_io_sel | input | 1 | Host I/O-space select |
| bus_rdata | output | CNT_W | Preset readback at the addressed register |
| frame_trig | output | 1 | One-cycle frame trigger |
| coarse_pulse | output | 1 | One-cycle coarse scan pulse |
| fine_pulse | output | 1 | One-cycle fine scan pulse |

## Verification
The bench drives both preset ends. A preset of 0 catches a counter that inserts an extra load cycle, which would fire one cycle late. A preset of 255 catches a counter that wraps or misses its stop, which would fire early or keep pulsing through the rest of the frame.

It rewrites a preset in the middle of a long count. A design that loaded the latch live would move that frame's pulse.

It also issues writes that lack the I/O select, lack the strobe, or target an unused address. A loose decode would show up as a changed readback and as shifted pulses in later frames.

Every trigger, pulse and absent pulse is matched against the exact predicted cycle. A divider that is off by one tick would shift each frame.

// File: rtl/sweep_delay_pulser.sv
module sweep_delay_pulser #(
  parameter int DIV       = 20,
  parameter int CNT_W     = 8,
  parameter int ADDR_W    = 4,
  parameter int BASE_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_io_sel,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              frame_trig,
  output logic              coarse_pulse,
  output logic              fine_pulse
);
  localparam int CH    = 2;
  localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [DIV_W-1:0]           div_q;
  logic                       trig_q;
  logic [CH-1:0][CNT_W-1:0]   preset_q;
  logic [CH-1:0][CNT_W-1:0]   cnt_q;
  logic [CH-1:0]              run_q;
  logic [CH-1:0]              fire;
  logic [CH-1:0]              sel;
  logic [CNT_W-1:0]           coarse_preset;
  logic [CNT_W-1:0]           fine_preset;

  wire div_last = (div_q == DIV_W'(DIV - 1));
  wire wr_hit   = bus_wr && bus_io_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= '0;
      trig_q <= 1'b0;
    end else begin
      trig_q <= tick_en && div_last;
      if (tick_en) div_q <= div_last ? '0 : div_q + 1'b1;
    end
  end

  always_comb begin
    for (int i = 0; i < CH; i++)
      sel[i] = (bus_addr == ADDR_W'(BASE_ADDR + i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      preset_q <= '0;
      cnt_q    <= '0;
      run_q    <= '0;
    end else begin
      for (int i = 0; i < CH; i++) begin
        if (wr_hit && sel[i]) preset_q[i] <= bus_wdata;
        if (trig_q) begin
          cnt_q[i] <= preset_q[i];
          run_q[i] <= 1'b1;
        end else if (run_q[i]) begin
          if (cnt_q[i] == '0) run_q[i] <= 1'b0;
          else                cnt_q[i] <= cnt_q[i] - 1'b1;
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < CH; i++) begin
      fire[i] = run_q[i] && (cnt_q[i] == '0);
      if (sel[i]) bus_rdata = preset_q[i];
    end
  end

  assign frame_trig    = trig_q;
  assign coarse_pulse  = fire[0];
  assign fine_pulse    = fire[1];
  assign coarse_preset = preset_q[0];
  assign fine_preset   = preset_q[1];
endmodule

module sweep_delay_pulser_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             bus_wr,
  input logic             bus_io_sel,
  input logic             frame_trig,
  input logic             coarse_pulse,
  input logic             fine_pulse,
  input logic [CNT_W-1:0] coarse_preset,
  input logic [CNT_W-1:0] fine_preset
);
  p_trig_narrow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_trig |=> !frame_trig);

  p_trig_from_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_trig |-> $past(tick_en));

  p_coarse_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    coarse_pulse && !frame_trig |=> !coarse_pulse);

  p_fine_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fine_pulse && !frame_trig |=> !fine_pulse);

  p_coarse_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_trig && coarse_preset == '0 |=> coarse_pulse);

  p_fine_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_trig && fine_preset == '0 |=> fine_pulse);

  p_hold_presets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_io_sel) |=> $stable(coarse_preset) && $stable(fine_preset));
endmodule

bind sweep_delay_pulser sweep_delay_pulser_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/sweep_delay_pulser_bench.sv
module sweep_delay_pulser_bench;
  localparam int CLK_NS = 500;
  localparam int DIV    = 20;
  localparam int GAP    = 16;

  logic       clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0;
  logic       bus_wr = 1'b0, bus_io_sel = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       frame_trig, coarse_pulse, fine_pulse;

  sweep_delay_pulser u_sweep_delay_pulser (.*);

  always #(CLK_NS/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  bit mon_on = 1'b0;
  logic [7:0] m_coarse = '0, m_fine = '0;
  int q_trig[$], q_c[$], q_f[$];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) if (mon_on) begin
    if (frame_trig) begin
      if (q_trig.size() == 0) chk("R2 unexpected trigger at cycle", cyc, -1);
      else chk("R2 trigger cycle", cyc, q_trig.pop_front());
    end else if (q_trig.size() != 0 && q_trig[0] == cyc) begin
      void'(q_trig.pop_front());
      chk("R2 trigger level at expected cycle", 0, 1);
    end
    if (coarse_pulse) begin
      if (q_c.size() == 0) chk("R3/R9 extra coarse pulse at cycle", cyc, -1);
      else chk("R3 coarse pulse cycle", cyc, q_c.pop_front());
    end else if (q_c.size() != 0 && q_c[0] == cyc) begin
      void'(q_c.pop_front());
      chk("R3 coarse level at expected cycle", 0, 1);
    end
    if (fine_pulse) begin
      if (q_f.size() == 0) chk("R4/R9 extra fine pulse at cycle", cyc, -1);
      else chk("R4 fine pulse cycle", cyc, q_f.pop_front());
    end else if (q_f.size() != 0 && q_f[0] == cyc) begin
      void'(q_f.pop_front());
      chk("R4 fine level at expected cycle", 0, 1);
    end
  end

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d,
                           input logic wr, input logic io);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = wr; bus_io_sel = io;
    if (wr && io && a == 4'd0) m_coarse = d;
    if (wr && io && a == 4'd1) m_fine = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_io_sel = 1'b0;
  endtask

  task automatic read_chk(input string req, input logic [3:0] a, input int exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    chk(req, int'(bus_rdata), exp);
  endtask

  task automatic run_frame(input int wtick, input logic [3:0] wa,
                           input logic [7:0] wd, input logic wio);
    for (int t = 0; t < DIV; t++) begin
      @(negedge clk);
      tick_en = 1'b1;
      if (t == DIV - 1) begin
        q_trig.push_back(cyc + 1);
        q_c.push_back(cyc + 2 + int'(m_coarse));
        q_f.push_back(cyc + 2 + int'(m_fine));
      end
      @(negedge clk);
      tick_en = 1'b0;
      if (t == wtick) bus_write(wa, wd, 1'b1, wio);
      repeat (GAP - 2) @(negedge clk);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 frame_trig in reset", int'(frame_trig), 0);
    chk("R1 coarse_pulse in reset", int'(coarse_pulse), 0);
    chk("R1 fine_pulse in reset", int'(fine_pulse), 0);
    rst_n = 1'b1;
    mon_on = 1'b1;
    read_chk("R1 coarse preset after reset", 4'd0, 0);
    read_chk("R1 fine preset after reset", 4'd1, 0);

    bus_write(4'd0, 8'd5, 1'b1, 1'b1);
    bus_write(4'd1, 8'd0, 1'b1, 1'b1);
    read_chk("R6 coarse readback", 4'd0, 5);
    read_chk("R6 fine readback", 4'd1, 0);

    bus_write(4'd1, 8'd9, 1'b1, 1'b0);
    read_chk("R7 write without io select", 4'd1, 0);
    bus_write(4'd0, 8'd9, 1'b0, 1'b1);
    read_chk("R7 write without strobe", 4'd0, 5);
    bus_write(4'd3, 8'h77, 1'b1, 1'b1);
    read_chk("R7 foreign address coarse", 4'd0, 5);
    read_chk("R7 foreign address fine", 4'd1, 0);
    read_chk("R7 foreign address reads zero", 4'd3, 0);

    run_frame(-1, 4'd0, 8'd0, 1'b0);          // R3 coarse 5, R5 fine 0
    run_frame(10, 4'd0, 8'd255, 1'b1);
    run_frame(10, 4'd1, 8'd128, 1'b1);        // R5 coarse 255
    run_frame(10, 4'd0, 8'd200, 1'b1);        // R8 write during coarse 255 count
    run_frame(3, 4'd1, 8'd7, 1'b0);           // R7 ignored write, fine stays 128
    run_frame(-1, 4'd0, 8'd0, 1'b0);
    repeat (300) @(negedge clk);

    chk("R9 pending triggers", q_trig.size(), 0);
    chk("R9 pending coarse pulses", q_c.size(), 0);
    chk("R9 pending fine pulses", q_f.size(), 0);
    read_chk("R8 coarse preset after mid-count write", 4'd0, 200);
    read_chk("R7 fine preset after ignored write", 4'd1, 128);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=finished", cyc);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule